// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block carries out a single four-word SDRAM burst read with auto-precharge. It starts when a request is taken and finishes on a done pulse. A request carries a bank, a row and a column, and it also carries the timing settings that apply to that access: the activate-to-read code, the read latency code, the precharge wait code, and a flag that is set when the internal and external clocks run 1:1. The block captures all four settings when the request is accepted.

The block drives the four active-low command pins, the address bus and the bank select. It samples the data bus in the four data cycles and returns each word on a 32-bit output with a one-cycle valid strobe. When the burst ends, the bank it used stays locked for a programmable number of cycles while the SDRAM finishes its internal precharge. A request for that bank stalls during this time. A request for any other bank is accepted at once.

Top module: `sdram_burst_rd`

## Requirements
- R1: The block accepts a request in a cycle where `req_valid` and `req_ready` are both high. In the next cycle it drives the activate command ({cs,ras,cas,we} = 0011), with `sd_addr` equal to the row and `sd_bank` equal to the requested bank.
- R2: The read command follows the activate command after 1, 2 or 3 cycles, for `cfg_rcd` codes 00, 01 and 10. Code 11 acts like 10. The block drives NOP (0111) in the cycles between the two commands and in every cycle that carries no other command.
- R3: The read command is {cs,ras,cas,we} = 0101. During it, `sd_addr` holds the column in its low bits with bit 10 set to request auto-precharge, and `sd_bank` holds the bank.
- R4: The first data capture comes `cfg_lat`+1 cycles after the read command, so codes 00 to 11 give 1 to 4 cycles. `sd_dq` is then sampled in four consecutive cycles.
- R5: `rd_valid` goes high for one cycle after each capture, four times in a row. In each of those cycles `rd_data` holds the word sampled in the cycle before.
- R6: The end wait after the fourth capture lasts 1 cycle when `cfg_ratio_1to1` is 0 and 2 cycles when it is 1. `rd_done` is high only in the last cycle of the end wait. The block is idle in the next cycle.
- R7: After `rd_done`, the bank just read stays locked for `cfg_trp`+1 cycles, so codes 00 to 11 give 1 to 4 cycles. During the lockout, `req_ready` is low for a request to that bank and no command is issued to it.
- R8: A request to a bank that is not locked is accepted in the first idle cycle, even while another bank is locked.
- R9: `req_ready` is low from the activate cycle through the `rd_done` cycle.
- R10: After reset, `req_ready` is high, the command is NOP, and `rd_valid` and `rd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A read request is present |
| req_ready | output | 1 | The block is idle and the requested bank is not locked |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 13 | Row address |
| req_col | input | 9 | Column address |
| cfg_rcd | input | 2 | Activate-to-read code |
| cfg_lat | input | 2 | Read-to-first-data code |
| cfg_trp | input | 2 | Precharge lockout code |
| cfg_ratio_1to1 | input | 1 | Set when the clocks run 1:1; lengthens the end wait |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | SDRAM address bus |
| sd_bank | output | 2 | SDRAM bank select |
| sd_dq | input | 32 | SDRAM read data |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| rd_done | output | 1 | Last cycle of the burst |

## Verification
Let request acceptance be cycle 0. The activate command is due in cycle 1 and the read command in cycle 1+rcd. The four captures fall in cycles 1+rcd+lat through 4+rcd+lat, where lat is the latency in cycles. Each `rd_valid` comes one cycle after its capture. `rd_done` falls in cycle 4+rcd+lat+tde, where tde is the end-wait length. A locked bank is free again exactly tap cycles after the cycle that follows `rd_done`. The bench recomputes these offsets every cycle from the acceptance cycle and its own per-bank lock counters. It then compares every output once per cycle, shortly after the falling edge, when inputs and outputs are settled. Requests go back to back on the same bank, on other banks and with the reserved activate code, so that the stall and bypass cases appear.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ACT, ST_GAP, ST_RD, ST_LAT, ST_DATA, ST_TDE
   } rd_state_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP  = 4'b0111;
   localparam logic [3:0] CMD_ACT  = 4'b0011;
   localparam logic [3:0] CMD_READ = 4'b0101;

   localparam int BURST_LEN = 4;
endpackage

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
   import sdram_rd_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 9,
   parameter int ADDR_W = 13,
   parameter int AP_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col,
   input  logic [1:0]        in_rcd,
   input  logic [1:0]        in_lat,
   input  logic [1:0]        in_trp,
   input  logic              in_ratio,
   output logic              idle,
   output logic [3:0]        cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] cur_bank,
   output logic              cap_en,
   output logic              done,
   output logic [2:0]        tap_cyc
);
   localparam int CNT_W = 3;

   rd_state_t          state;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   rcd_q, lat_q;
   logic               ratio_q;
   logic [ROW_W-1:0]   row_q;
   logic [COL_W-1:0]   col_q;
   logic [CNT_W-1:0]   rcd_cyc;

   assign rcd_cyc = (in_rcd == 2'b11) ? 3'd3 : ({1'b0, in_rcd} + 3'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         rcd_q    <= 3'd1;
         lat_q    <= 3'd1;
         ratio_q  <= 1'b0;
         row_q    <= '0;
         col_q    <= '0;
         cur_bank <= '0;
         tap_cyc  <= 3'd1;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_ACT;
               rcd_q    <= rcd_cyc;
               lat_q    <= {1'b0, in_lat} + 3'd1;
               tap_cyc  <= {1'b0, in_trp} + 3'd1;
               ratio_q  <= in_ratio;
               row_q    <= in_row;
               col_q    <= in_col;
               cur_bank <= in_bank;
            end
            ST_ACT: begin
               if (rcd_q == 3'd1) state <= ST_RD;
               else begin
                  state <= ST_GAP;
                  cnt   <= rcd_q - 3'd1;
               end
            end
            ST_GAP: begin
               if (cnt == 3'd1) state <= ST_RD;
               else cnt <= cnt - 3'd1;
            end
            ST_RD: begin
               if (lat_q == 3'd1) begin
                  state <= ST_DATA;
                  cnt   <= CNT_W'(BURST_LEN);
               end else begin
                  state <= ST_LAT;
                  cnt   <= lat_q - 3'd1;
               end
            end
            ST_LAT: begin
               if (cnt == 3'd1) begin
                  state <= ST_DATA;
                  cnt   <= CNT_W'(BURST_LEN);
               end else cnt <= cnt - 3'd1;
            end
            ST_DATA: begin
               if (cnt == 3'd1) begin
                  state <= ST_TDE;
                  cnt   <= ratio_q ? 3'd2 : 3'd1;
               end else cnt <= cnt - 3'd1;
            end
            ST_TDE: begin
               if (cnt == 3'd1) state <= ST_IDLE;
               else cnt <= cnt - 3'd1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      if (state == ST_ACT) begin
         cmd  = CMD_ACT;
         addr = ADDR_W'(row_q);
      end else if (state == ST_RD) begin
         cmd          = CMD_READ;
         addr         = ADDR_W'(col_q);
         addr[AP_BIT] = 1'b1;
      end
   end

   assign idle   = (state == ST_IDLE);
   assign cap_en = (state == ST_DATA);
   assign done   = (state == ST_TDE) && (cnt == 3'd1);

   assert_act_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start) |=> (cmd == CMD_ACT));
   assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> idle);
   assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_NOP) || (cmd == CMD_ACT) || (cmd == CMD_READ));
   assert_read_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT && rcd_q == 3'd1) |=> (cmd == CMD_READ));
endmodule

// File: rtl/sdram_bank_lock.sv
module sdram_bank_lock #(
   parameter int NBANKS = 4,
   parameter int BANK_W = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] load_bank,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [BANK_W-1:0] query_bank,
   output logic              query_busy,
   output logic [NBANKS-1:0] busy_vec
);
   for (genvar g = 0; g < NBANKS; g++) begin : g_bank
      logic [CNT_W-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) left <= '0;
         else if (load && (load_bank == BANK_W'(g))) left <= load_val;
         else if (left != '0) left <= left - 1'b1;
      end
      assign busy_vec[g] = (left != '0);
   end

   assign query_busy = busy_vec[query_bank];
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] dq,
   output logic [DATA_W-1:0] data,
   output logic              valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= cap_en;
         if (cap_en) data <= dq;
      end
   end
endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
   import sdram_rd_pkg::*;
#(
   parameter int NBANKS = 4,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 9,
   parameter int ADDR_W = 13,
   parameter int AP_BIT = 10,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [$clog2(NBANKS)-1:0] req_bank,
   input  logic [ROW_W-1:0]          req_row,
   input  logic [COL_W-1:0]          req_col,
   input  logic [1:0]                cfg_rcd,
   input  logic [1:0]                cfg_lat,
   input  logic [1:0]                cfg_trp,
   input  logic                      cfg_ratio_1to1,
   output logic                      sd_cs_n,
   output logic                      sd_ras_n,
   output logic                      sd_cas_n,
   output logic                      sd_we_n,
   output logic [ADDR_W-1:0]         sd_addr,
   output logic [$clog2(NBANKS)-1:0] sd_bank,
   input  logic [DATA_W-1:0]         sd_dq,
   output logic [DATA_W-1:0]         rd_data,
   output logic                      rd_valid,
   output logic                      rd_done
);
   localparam int BANK_W = $clog2(NBANKS);

   if (NBANKS < 2 || (1 << BANK_W) != NBANKS) begin : g_chk_banks
      $error("NBANKS must be a power of two of at least 2");
   end
   if (AP_BIT >= ADDR_W || COL_W > AP_BIT || ROW_W > ADDR_W) begin : g_chk_addr
      $error("address field widths do not fit the address bus");
   end

   logic              idle, start, lock_hit, cap_en, done;
   logic [3:0]        cmd;
   logic [2:0]        tap_cyc;
   logic [BANK_W-1:0] cur_bank;
   logic [NBANKS-1:0] lock_vec;

   assign req_ready = idle && !lock_hit;
   assign start     = req_valid && req_ready;

   sdram_rd_seq #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
      .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_bank(req_bank), .in_row(req_row), .in_col(req_col),
      .in_rcd(cfg_rcd), .in_lat(cfg_lat), .in_trp(cfg_trp),
      .in_ratio(cfg_ratio_1to1),
      .idle(idle), .cmd(cmd), .addr(sd_addr), .cur_bank(cur_bank),
      .cap_en(cap_en), .done(done), .tap_cyc(tap_cyc)
   );

   sdram_bank_lock #(
      .NBANKS(NBANKS), .BANK_W(BANK_W), .CNT_W(3)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .load(done), .load_bank(cur_bank),
      .load_val(tap_cyc), .query_bank(req_bank),
      .query_busy(lock_hit), .busy_vec(lock_vec)
   );

   sdram_rd_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .dq(sd_dq),
      .data(rd_data), .valid(rd_valid)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_bank = cur_bank;
   assign rd_done = done;

   assert_no_act_locked_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> !lock_vec[cur_bank]);
   assert_not_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> !req_ready);
   assert_valid_after_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_en) |-> rd_valid);
endmodule

// File: tb/sdram_burst_rd_bench.sv
module sdram_burst_rd_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_bank = '0;
   logic [12:0] req_row = '0;
   logic [8:0]  req_col = '0;
   logic [1:0]  cfg_rcd = '0, cfg_lat = '0, cfg_trp = '0;
   logic        cfg_ratio_1to1 = 1'b0;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [12:0] sd_addr;
   logic [1:0]  sd_bank;
   logic [31:0] sd_dq = '0;
   logic [31:0] rd_data;
   logic        rd_valid, rd_done;

   always #4 clk = ~clk;

   sdram_burst_rd u_sdram_burst_rd (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .cfg_rcd(cfg_rcd), .cfg_lat(cfg_lat), .cfg_trp(cfg_trp),
      .cfg_ratio_1to1(cfg_ratio_1to1),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_addr(sd_addr), .sd_bank(sd_bank), .sd_dq(sd_dq),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
   );

   int checks = 0, fails = 0;
   int cyc = 0;
   // next-cycle drive values
   logic        n_valid = 1'b0;
   logic [1:0]  n_bank = '0, n_rcd = '0, n_lat = '0, n_trp = '0;
   logic [12:0] n_row = '0;
   logic [8:0]  n_col = '0;
   logic        n_ratio = 1'b0;
   // reference model state
   bit          busy = 0, accepted = 0, prev_cap = 0;
   int          acc_cyc = 0, m_rcd = 1, m_lat = 1, m_tap = 1, m_tde = 1;
   logic [1:0]  m_bank = '0;
   logic [12:0] m_row = '0;
   logic [8:0]  m_col = '0;
   int          lock [4] = '{0, 0, 0, 0};

   function automatic logic [31:0] pat(int c);
      return 32'h1234_5678 ^ (32'(c) * 32'h9E37_79B9);
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic step();
      int o, done_off;
      bit e_ready, e_cap, e_done;
      logic [3:0] e_cmd, a_cmd;
      string rtag, ctag;
      @(negedge clk);
      req_valid = n_valid; req_bank = n_bank; req_row = n_row; req_col = n_col;
      cfg_rcd = n_rcd; cfg_lat = n_lat; cfg_trp = n_trp; cfg_ratio_1to1 = n_ratio;
      sd_dq = pat(cyc);
      #1;
      o = cyc - acc_cyc;
      done_off = 4 + m_rcd + m_lat + m_tde;
      e_ready = !busy && (lock[req_bank] == 0);
      e_cmd = 4'b0111; ctag = "R2";
      if (busy && o == 1) begin e_cmd = 4'b0011; ctag = "R1"; end
      else if (busy && o == 1 + m_rcd) begin e_cmd = 4'b0101; ctag = "R3"; end
      e_cap  = busy && (o >= 1 + m_rcd + m_lat) && (o <= 4 + m_rcd + m_lat);
      e_done = busy && (o == done_off);
      rtag = busy ? "R9" : ((lock[req_bank] != 0) ? "R7" : "R8");
      a_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      chk(req_ready == e_ready, rtag, 32'(req_ready), 32'(e_ready));
      chk(a_cmd == e_cmd, ctag, 32'(a_cmd), 32'(e_cmd));
      chk(rd_valid == prev_cap, "R4/R5 valid", 32'(rd_valid), 32'(prev_cap));
      chk(rd_done == e_done, "R6 done", 32'(rd_done), 32'(e_done));
      if (e_cmd == 4'b0011) begin
         chk(sd_addr == m_row, "R1 row", 32'(sd_addr), 32'(m_row));
         chk(sd_bank == m_bank, "R1 bank", 32'(sd_bank), 32'(m_bank));
      end
      if (e_cmd == 4'b0101) begin
         chk(sd_addr == (13'(m_col) | 13'h400), "R3 col", 32'(sd_addr), 32'(13'(m_col) | 13'h400));
         chk(sd_bank == m_bank, "R3 bank", 32'(sd_bank), 32'(m_bank));
      end
      if (prev_cap && rd_valid)
         chk(rd_data == pat(cyc - 1), "R5 data", rd_data, pat(cyc - 1));
      @(posedge clk);
      prev_cap = e_cap;
      for (int b = 0; b < 4; b++) begin
         if (e_done && b == int'(m_bank)) lock[b] = m_tap;
         else if (lock[b] > 0) lock[b]--;
      end
      if (e_done) busy = 0;
      accepted = 0;
      if (req_valid && e_ready) begin
         busy = 1; accepted = 1; acc_cyc = cyc;
         m_bank = req_bank; m_row = req_row; m_col = req_col;
         m_rcd = (cfg_rcd == 2'b11) ? 3 : int'(cfg_rcd) + 1;
         m_lat = int'(cfg_lat) + 1;
         m_tap = int'(cfg_trp) + 1;
         m_tde = cfg_ratio_1to1 ? 2 : 1;
      end
      cyc++;
      if (cyc > 20000) begin
         chk(0, "watchdog", 32'(cyc), 32'd20000);
         finish_run();
      end
   endtask

   task automatic request(logic [1:0] b, logic [12:0] r, logic [8:0] c,
                          logic [1:0] rcd, logic [1:0] lat, logic [1:0] trp, logic ratio);
      n_valid = 1; n_bank = b; n_row = r; n_col = c;
      n_rcd = rcd; n_lat = lat; n_trp = trp; n_ratio = ratio;
      do step(); while (!accepted);
      n_valid = 0;
   endtask

   task automatic idle_steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state
      chk(req_ready === 1'b1, "R10 ready", 32'(req_ready), 32'd1);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === 4'b0111, "R10 cmd",
          32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
      chk(rd_valid === 1'b0 && rd_done === 1'b0, "R10 strobes",
          32'({rd_valid, rd_done}), 32'd0);
      idle_steps(2);
      request(2'd0, 13'h1ABC, 9'h055, 2'b00, 2'b00, 2'b11, 1'b0);
      request(2'd0, 13'h0F0F, 9'h1AA, 2'b01, 2'b01, 2'b00, 1'b1); // R7 stall
      request(2'd1, 13'h1234, 9'h0FF, 2'b10, 2'b11, 2'b01, 1'b0); // R8 bypass
      request(2'd1, 13'h0001, 9'h100, 2'b11, 2'b10, 2'b10, 1'b1); // R2 code 11
      request(2'd2, 13'h1FFF, 9'h1FF, 2'b01, 2'b00, 2'b11, 1'b1);
      request(2'd3, 13'h0800, 9'h000, 2'b00, 2'b11, 2'b11, 1'b0);
      request(2'd3, 13'h0555, 9'h0AA, 2'b10, 2'b01, 2'b00, 1'b0); // R7 max lock
      request(2'd2, 13'h02AA, 9'h123, 2'b00, 2'b00, 2'b00, 1'b0);
      idle_steps(30);
      finish_run();
   end
endmodule